// File: doc/BRIEF.md
# Word-Packing UART Receiver with Idle Timeout

This block receives serial characters in 8-N-1 format and collects them, four at a time, into 32-bit words that are queued in a small receive FIFO. Software reads the queue one word at a time. The oldest word is visible on the read-data port while the ready flag is high.

Reception is grouped into transfers. Software writes an expected character count, and that write opens a transfer. A transfer closes in one of two ways. The first is that the programmed number of characters has arrived. The second applies when the idle timeout is enabled: the line then stays quiet for a programmable number of character times. When a transfer closes, the number of characters it accepted is latched into a snapshot output. Any half-built word is queued with its unused upper bytes set to zero.

An idle-timeout flag and a sticky overrun flag report events. Each flag has its own clear command, and the idle timeout can be enabled or disabled by command.

Top module: `uart_word_rx`

## Requirements
- R1: A character is a low start bit, eight data bits sent least significant bit first, and a stop bit. Each bit is sampled at its centre, one bit time being CLKS_PER_BIT clocks. The line idles high.
- R2: Within a word, the first character of the word goes to bits 7:0, the second to 15:8, the third to 23:16 and the fourth to 31:24. A word is queued as soon as its fourth character arrives.
- R3: A pulse on `xferWr` opens a transfer whose target is `xferCount`. It clears the character count and discards any half-built word. Characters that arrive while no transfer is open are ignored.
- R4: When the character count of an open transfer reaches the target, the transfer closes. A half-built word is then queued with zero upper bytes, and `snapCount` takes the target value.
- R5: The idle timeout is enabled, and an open transfer holds at least one character. When `staleTimeout` character times (10 bit times each) have passed since the most recent start bit, the transfer closes. `staleIrq` sets and `snapCount` takes the number of accepted characters. A half-built word is queued zero-padded, and no word is queued if none is half-built.
- R6: The idle timeout is disabled after reset. `cmdStaleEn` enables it and `cmdStaleDis` disables it. While it is disabled, idle time never closes a transfer.
- R7: `staleIrq` stays set until a `cmdStaleClr` pulse clears it.
- R8: `rxReady` is high exactly when the FIFO holds at least one word. `rdData` shows the oldest word. `popReq` removes that word, and `popReq` on an empty FIFO has no effect.
- R9: A word that must be queued while the FIFO is full is discarded, and `overrun` sets. `overrun` stays set until a `cmdErrClr` pulse clears it.
- R10: After reset, `rxReady`, `overrun`, `staleIrq` and `snapCount` are zero, and no transfer is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxLine | input | 1 | Serial receive line, idle high |
| xferWr | input | 1 | Pulse: open a transfer with target `xferCount` |
| xferCount | input | CNT_W | Expected characters in the transfer |
| staleTimeout | input | TMO_W | Idle timeout in character times |
| cmdStaleEn | input | 1 | Pulse: enable the idle timeout |
| cmdStaleDis | input | 1 | Pulse: disable the idle timeout |
| cmdStaleClr | input | 1 | Pulse: clear `staleIrq` |
| cmdErrClr | input | 1 | Pulse: clear `overrun` |
| popReq | input | 1 | Pulse: remove the oldest FIFO word |
| rxReady | output | 1 | FIFO holds at least one word |
| rdData | output | 32 | Oldest FIFO word |
| overrun | output | 1 | Sticky: a word was discarded on a full FIFO |
| staleIrq | output | 1 | Sticky: a transfer closed on idle timeout |
| snapCount | output | CNT_W | Characters accepted by the last closed transfer |

## Verification
The assertions check four things on every cycle. A character is delivered only from the stop-bit phase. The character count never passes the target. The idle flag can rise only while the timeout is enabled. The snapshot moves only on the cycle a transfer closes. They also check that overrun rises only on a push into a full FIFO, and that a pop on an empty FIFO leaves the read side untouched.

Some behaviour only the bench's scenarios can show:
- the byte order inside queued words and the zero padding of partial words;
- the idle timeout firing neither early nor while disabled;
- the discard of a half-built word when a transfer is reopened;
- the exact words that survive an overrun.

// File: rtl/uart_word_rx_pkg.sv
package uart_word_rx_pkg;
  localparam int LANES  = 4;
  localparam int BYTE_W = 8;
  localparam int WORD_W = LANES * BYTE_W;
  localparam int LANE_W = $clog2(LANES);

  typedef struct packed {
    logic              loadByte;
    logic              pushWord;
    logic              clearPack;
    logic              clearErr;
    logic [LANE_W-1:0] lane;
  } packStrobe_t;
endpackage

// File: rtl/rx_bit_sampler.sv
module rx_bit_sampler #(
  parameter int CLKS_PER_BIT = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxLine,
  output logic       charValid,
  output logic [7:0] charByte,
  output logic       startPulse,
  output logic       busy
);
  localparam int CW   = $clog2(CLKS_PER_BIT);
  localparam int HALF = CLKS_PER_BIT / 2;

  typedef enum logic [1:0] {S_IDLE, S_START, S_DATA, S_STOP} sampState_t;

  sampState_t state;
  logic [1:0] syncReg;
  logic [CW-1:0] cnt;
  logic [2:0] bitIdx;
  logic [7:0] shiftReg;
  logic lineS;

  assign lineS    = syncReg[1];
  assign charByte = shiftReg;
  assign busy     = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncReg    <= 2'b11;
      state      <= S_IDLE;
      cnt        <= '0;
      bitIdx     <= '0;
      shiftReg   <= '0;
      charValid  <= 1'b0;
      startPulse <= 1'b0;
    end else begin
      syncReg    <= {syncReg[0], rxLine};
      charValid  <= 1'b0;
      startPulse <= 1'b0;
      case (state)
        S_IDLE: if (!lineS) begin
          state      <= S_START;
          cnt        <= '0;
          startPulse <= 1'b1;
        end
        S_START: if (cnt == CW'(HALF - 1)) begin
          cnt    <= '0;
          bitIdx <= '0;
          state  <= lineS ? S_IDLE : S_DATA;
        end else cnt <= cnt + 1'b1;
        S_DATA: if (cnt == CW'(CLKS_PER_BIT - 1)) begin
          cnt      <= '0;
          shiftReg <= {lineS, shiftReg[7:1]};
          bitIdx   <= bitIdx + 1'b1;
          if (bitIdx == 3'd7) state <= S_STOP;
        end else cnt <= cnt + 1'b1;
        default: if (cnt == CW'(CLKS_PER_BIT - 1)) begin
          cnt       <= '0;
          charValid <= 1'b1;
          state     <= S_IDLE;
        end else cnt <= cnt + 1'b1;
      endcase
    end
  end

  // R1: a character is only delivered after the stop-bit phase
  assert_char_from_stop_R1: assert property (@(posedge clk) disable iff (!rstN)
    charValid |-> $past(state == S_STOP));
endmodule

// File: rtl/rx_xfer_ctrl.sv
module rx_xfer_ctrl
  import uart_word_rx_pkg::*;
#(
  parameter int CLKS_PER_BIT = 16,
  parameter int CNT_W        = 16,
  parameter int TMO_W        = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             charValid,
  input  logic             startPulse,
  input  logic             rxBusy,
  input  logic             xferWr,
  input  logic [CNT_W-1:0] xferCount,
  input  logic [TMO_W-1:0] staleTimeout,
  input  logic             cmdStaleEn,
  input  logic             cmdStaleDis,
  input  logic             cmdStaleClr,
  input  logic             cmdErrClr,
  output packStrobe_t      strobes,
  output logic             staleIrq,
  output logic [CNT_W-1:0] snapCount
);
  localparam int CHAR_CLKS = 10 * CLKS_PER_BIT;
  localparam int TW        = $clog2(CHAR_CLKS);

  logic             xferActive;
  logic [CNT_W-1:0] target;
  logic [CNT_W-1:0] charCnt;
  logic [CNT_W-1:0] cntNext;
  logic [LANE_W-1:0] lane;
  logic             staleEn;
  logic [TW-1:0]    tickCnt;
  logic [TMO_W-1:0] charTimes;
  logic             acceptChar;
  logic             reachTarget;
  logic             staleFire;

  always_comb begin
    acceptChar  = charValid && xferActive && !xferWr;
    cntNext     = charCnt + 1'b1;
    reachTarget = acceptChar && (cntNext == target);
    staleFire   = xferActive && !xferWr && staleEn && !acceptChar && !rxBusy &&
                  (charCnt != '0) && (charTimes >= staleTimeout);
    strobes.loadByte  = acceptChar;
    strobes.lane      = lane;
    strobes.pushWord  = (acceptChar && ((lane == LANE_W'(LANES - 1)) || reachTarget)) ||
                        (staleFire && (lane != '0));
    strobes.clearPack = xferWr;
    strobes.clearErr  = cmdErrClr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tickCnt   <= '0;
      charTimes <= '0;
    end else if (startPulse || xferWr) begin
      tickCnt   <= '0;
      charTimes <= '0;
    end else if (tickCnt == TW'(CHAR_CLKS - 1)) begin
      tickCnt <= '0;
      if (charTimes != '1) charTimes <= charTimes + 1'b1;
    end else begin
      tickCnt <= tickCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      staleEn    <= 1'b0;
      staleIrq   <= 1'b0;
      xferActive <= 1'b0;
      target     <= '0;
      charCnt    <= '0;
      lane       <= '0;
      snapCount  <= '0;
    end else begin
      if (cmdStaleEn) staleEn <= 1'b1;
      else if (cmdStaleDis) staleEn <= 1'b0;
      if (staleFire) staleIrq <= 1'b1;
      else if (cmdStaleClr) staleIrq <= 1'b0;
      if (xferWr) begin
        xferActive <= 1'b1;
        target     <= xferCount;
        charCnt    <= '0;
        lane       <= '0;
      end else if (acceptChar) begin
        charCnt <= cntNext;
        lane    <= strobes.pushWord ? '0 : lane + 1'b1;
        if (reachTarget) begin
          xferActive <= 1'b0;
          snapCount  <= cntNext;
        end
      end else if (staleFire) begin
        xferActive <= 1'b0;
        snapCount  <= charCnt;
        lane       <= '0;
      end
    end
  end

  // R4: the count never runs past a non-zero target
  assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    (xferActive && target != '0) |-> (charCnt < target));
  // R6: idle flag can only rise while the timeout is enabled
  assert_stale_needs_enable_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(staleIrq) |-> $past(staleEn));
  // R5: snapshot moves only when a transfer closes
  assert_snap_at_close_R5: assert property (@(posedge clk) disable iff (!rstN)
    (snapCount != $past(snapCount)) |-> ($past(xferActive) && !xferActive));
endmodule

// File: rtl/rx_pack_fifo.sv
module rx_pack_fifo
  import uart_word_rx_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  packStrobe_t       strobes,
  input  logic [BYTE_W-1:0] charByte,
  input  logic              popReq,
  output logic              rxReady,
  output logic [WORD_W-1:0] rdData,
  output logic              overrun
);
  localparam int AW = $clog2(DEPTH);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] packReg;
  logic [WORD_W-1:0] nextWord;
  logic [AW:0] wrPtr, rdPtr;
  logic full, empty;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign nextWord[g*BYTE_W +: BYTE_W] =
      (strobes.loadByte && strobes.lane == LANE_W'(g)) ? charByte
                                                        : packReg[g*BYTE_W +: BYTE_W];
  end

  assign empty   = (wrPtr == rdPtr);
  assign full    = (wrPtr[AW] != rdPtr[AW]) && (wrPtr[AW-1:0] == rdPtr[AW-1:0]);
  assign rxReady = !empty;
  assign rdData  = mem[rdPtr[AW-1:0]];

  always_ff @(posedge clk) begin
    if (strobes.pushWord && !full) mem[wrPtr[AW-1:0]] <= nextWord;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      packReg <= '0;
      wrPtr   <= '0;
      rdPtr   <= '0;
      overrun <= 1'b0;
    end else begin
      if (strobes.clearPack || strobes.pushWord) packReg <= '0;
      else if (strobes.loadByte) packReg <= nextWord;
      if (strobes.pushWord && !full) wrPtr <= wrPtr + 1'b1;
      if (strobes.pushWord && full) overrun <= 1'b1;
      else if (strobes.clearErr) overrun <= 1'b0;
      if (popReq && !empty) rdPtr <= rdPtr + 1'b1;
    end
  end

  // R9: overrun only rises because of a push into a full FIFO
  assert_overrun_cause_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrun) |-> $past(strobes.pushWord && full));
  // R8: popping an empty FIFO leaves the read pointer alone
  assert_pop_empty_R8: assert property (@(posedge clk) disable iff (!rstN)
    (popReq && empty) |=> (rdPtr == $past(rdPtr)));
endmodule

// File: rtl/uart_word_rx.sv
module uart_word_rx
  import uart_word_rx_pkg::*;
#(
  parameter int CLKS_PER_BIT = 16,
  parameter int FIFO_DEPTH   = 8,
  parameter int CNT_W        = 16,
  parameter int TMO_W        = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxLine,
  input  logic             xferWr,
  input  logic [CNT_W-1:0] xferCount,
  input  logic [TMO_W-1:0] staleTimeout,
  input  logic             cmdStaleEn,
  input  logic             cmdStaleDis,
  input  logic             cmdStaleClr,
  input  logic             cmdErrClr,
  input  logic             popReq,
  output logic             rxReady,
  output logic [31:0]      rdData,
  output logic             overrun,
  output logic             staleIrq,
  output logic [CNT_W-1:0] snapCount
);
  logic charValid, startPulse, rxBusy;
  logic [7:0] charByte;
  packStrobe_t strobes;

  rx_bit_sampler #(.CLKS_PER_BIT(CLKS_PER_BIT)) uSampler (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .charValid(charValid),
    .charByte(charByte), .startPulse(startPulse), .busy(rxBusy));

  rx_xfer_ctrl #(.CLKS_PER_BIT(CLKS_PER_BIT), .CNT_W(CNT_W), .TMO_W(TMO_W)) uCtrl (
    .clk(clk), .rstN(rstN), .charValid(charValid), .startPulse(startPulse),
    .rxBusy(rxBusy), .xferWr(xferWr), .xferCount(xferCount),
    .staleTimeout(staleTimeout), .cmdStaleEn(cmdStaleEn), .cmdStaleDis(cmdStaleDis),
    .cmdStaleClr(cmdStaleClr), .cmdErrClr(cmdErrClr), .strobes(strobes),
    .staleIrq(staleIrq), .snapCount(snapCount));

  rx_pack_fifo #(.DEPTH(FIFO_DEPTH)) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .charByte(charByte),
    .popReq(popReq), .rxReady(rxReady), .rdData(rdData), .overrun(overrun));
endmodule

// File: tb/tb_uart_word_rx.sv
module tb_uart_word_rx;
  localparam int CPB   = 8;
  localparam int DEPTH = 4;

  logic clk = 1'b0, rstN = 1'b0, rxLine = 1'b1;
  logic xferWr = 1'b0, cmdStaleEn = 1'b0, cmdStaleDis = 1'b0;
  logic cmdStaleClr = 1'b0, cmdErrClr = 1'b0, popReq = 1'b0;
  logic [15:0] xferCount = '0;
  logic [7:0]  staleTimeout = 8'd2;
  logic rxReady, overrun, staleIrq;
  logic [31:0] rdData;
  logic [15:0] snapCount;

  int checkCount = 0;
  int failCount  = 0;
  bit finished   = 1'b0;
  logic [31:0] expQ[$];
  logic [7:0]  chars[$];

  uart_word_rx #(.CLKS_PER_BIT(CPB), .FIFO_DEPTH(DEPTH), .CNT_W(16), .TMO_W(8)) dut (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .xferWr(xferWr), .xferCount(xferCount),
    .staleTimeout(staleTimeout), .cmdStaleEn(cmdStaleEn), .cmdStaleDis(cmdStaleDis),
    .cmdStaleClr(cmdStaleClr), .cmdErrClr(cmdErrClr), .popReq(popReq),
    .rxReady(rxReady), .rdData(rdData), .overrun(overrun), .staleIrq(staleIrq),
    .snapCount(snapCount));

  always #4 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checkCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendChar(input logic [7:0] b);
    rxLine = 1'b0; waitClk(CPB);
    for (int i = 0; i < 8; i++) begin rxLine = b[i]; waitClk(CPB); end
    rxLine = 1'b1; waitClk(CPB);
  endtask

  task automatic startXfer(input int n);
    @(negedge clk); xferCount = 16'(n); xferWr = 1'b1;
    @(negedge clk); xferWr = 1'b0;
  endtask

  // reference packing: words of four, earliest char lowest, zero padded
  task automatic expectWords(input int n);
    for (int w = 0; w < n; w += 4) begin
      logic [31:0] word = '0;
      for (int k = 0; k < 4 && w + k < n; k++) word[k*8 +: 8] = chars[w + k];
      expQ.push_back(word);
    end
  endtask

  task automatic sendChars(input int n, input int seed);
    chars.delete();
    for (int i = 0; i < n; i++) begin
      chars.push_back(8'((seed + i * 37) ^ 8'h5A));
      sendChar(chars[i]);
    end
  endtask

  task automatic drainCheck(input string tag);
    while (expQ.size() != 0) begin
      check(rxReady == 1'b1, tag, 32'(rxReady), 32'd1);
      check(rdData == expQ[0], tag, rdData, expQ[0]);
      void'(expQ.pop_front());
      @(negedge clk); popReq = 1'b1;
      @(negedge clk); popReq = 1'b0;
    end
    check(rxReady == 1'b0, {tag, " empty"}, 32'(rxReady), 32'd0);
  endtask

  initial begin
    waitClk(5); rstN = 1'b1; waitClk(1);
    // R10 reset state
    check(rxReady == 0, "R10 rxReady", 32'(rxReady), 0);
    check(overrun == 0, "R10 overrun", 32'(overrun), 0);
    check(staleIrq == 0, "R10 staleIrq", 32'(staleIrq), 0);
    check(snapCount == 0, "R10 snapCount", 32'(snapCount), 0);

    // R3: char without an open transfer is ignored
    sendChar(8'h55); waitClk(5);
    check(rxReady == 0, "R3 ignored idle", 32'(rxReady), 0);

    // R1 R2 R4: count-terminated transfer of 6
    startXfer(6); sendChars(6, 17); waitClk(5);
    check(snapCount == 6, "R4 snap", 32'(snapCount), 6);
    expectWords(6); drainCheck("R2 R4 words");

    // R8: pop on empty has no effect
    @(negedge clk); popReq = 1'b1; @(negedge clk); popReq = 1'b0;
    check(rxReady == 0, "R8 pop empty", 32'(rxReady), 0);

    // R5: idle timeout with a partial word
    @(negedge clk); cmdStaleEn = 1'b1; @(negedge clk); cmdStaleEn = 1'b0;
    startXfer(10); sendChars(3, 90); waitClk(30);
    check(staleIrq == 0, "R5 not early", 32'(staleIrq), 0);
    waitClk(100);
    check(staleIrq == 1, "R5 fired", 32'(staleIrq), 1);
    check(snapCount == 3, "R5 snap", 32'(snapCount), 3);
    expectWords(3); drainCheck("R5 partial word");

    // R7: clear idle flag
    @(negedge clk); cmdStaleClr = 1'b1; @(negedge clk); cmdStaleClr = 1'b0;
    check(staleIrq == 0, "R7 clear", 32'(staleIrq), 0);

    // R5: idle timeout on a word boundary queues no extra word
    startXfer(10); sendChars(4, 3); waitClk(300);
    check(staleIrq == 1, "R5 boundary fired", 32'(staleIrq), 1);
    check(snapCount == 4, "R5 boundary snap", 32'(snapCount), 4);
    expectWords(4); drainCheck("R5 boundary words");
    @(negedge clk); cmdStaleClr = 1'b1; @(negedge clk); cmdStaleClr = 1'b0;

    // R6: disabled timeout never closes a transfer
    @(negedge clk); cmdStaleDis = 1'b1; @(negedge clk); cmdStaleDis = 1'b0;
    startXfer(10); sendChars(2, 200); waitClk(400);
    check(staleIrq == 0, "R6 disabled", 32'(staleIrq), 0);
    check(rxReady == 0, "R6 nothing queued", 32'(rxReady), 0);

    // R3: reopening discards the half-built word
    startXfer(4); sendChars(4, 61); waitClk(5);
    check(snapCount == 4, "R3 reopen snap", 32'(snapCount), 4);
    expectWords(4); drainCheck("R3 reopen words");
    sendChar(8'hC3); waitClk(5);
    check(rxReady == 0, "R3 ignored after close", 32'(rxReady), 0);
    check(snapCount == 4, "R3 snap kept", 32'(snapCount), 4);

    // R9: overrun on a full FIFO
    startXfer(20); sendChars(20, 11); waitClk(5);
    check(overrun == 1, "R9 overrun set", 32'(overrun), 1);
    check(snapCount == 20, "R9 snap", 32'(snapCount), 20);
    expectWords(16); drainCheck("R9 surviving words");
    @(negedge clk); cmdErrClr = 1'b1; @(negedge clk); cmdErrClr = 1'b0;
    check(overrun == 0, "R9 clear", 32'(overrun), 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checkCount++;
      failCount++;
      $display("FAIL watchdog: actual %h expected %h", 32'd0, 32'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
      $finish;
    end
  end
endmodule